// File: doc/BRIEF.md
# Serial Slave Front End with Clock-Mode Detection

This block sits between the four pins of a serial peripheral link and the command decoder of a storage device. It samples chip select, serial clock and serial data in with the system clock through synchronisers. It finds the edges of the serial clock in the system-clock domain and uses them to move data in both directions. Data is received on rising serial-clock edges and driven out on falling edges, most significant bit first. Each completed byte is handed to the command logic with a one-cycle strobe. Output bytes are taken from the command logic at the start of a frame and at every byte boundary.

The clock polarity of the host is not configured. Each time chip select goes low, the block looks at the level the serial clock rests at and selects mode 3 (clock idles high) or mode 0 (clock idles low). After reset it assumes mode 3. The serial output has a separate enable. The enable is low whenever chip select is high, and it is also low after reset until a real chip-select falling edge has been seen.

Top module: `spi_autodetect_slave`

## Requirements
- R1: While reset is applied and afterwards until the first frame starts, `mode_is3` is 1, `sdo_oe` is 0 and none of `rx_valid`, `frame_start`, `frame_end` pulses.
- R2: At each chip-select falling edge the serial-clock level is sampled: high gives `mode_is3`=1 (mode 3), low gives `mode_is3`=0 (mode 0). The value holds until the next falling edge of chip select.
- R3: Input bits are captured on rising serial-clock edges, most significant bit first. After every 8th rising edge of a frame, `rx_valid` pulses for one cycle with the byte on `rx_data`. Bits of an incomplete last byte are discarded when the frame ends.
- R4: `sdo` changes only on falling serial-clock edges that follow at least one rising edge of the frame. At the j-th rising edge of a frame (counting from 0), `sdo` carries bit 7-(j mod 8) of the (j div 8)-th byte taken from `tx_byte`.
- R5: At the start of a frame, the current `tx_byte` is loaded and `tx_load` pulses. In mode 0, its bit 7 is therefore on `sdo` with `sdo_oe`=1 before any clock edge. `tx_load` pulses again at every falling edge that follows a multiple of 8 rising edges, and the new `tx_byte` is loaded at that edge.
- R6: While chip select is high, `sdo_oe` is 0 and serial-clock and data activity produces no `rx_valid`.
- R7: `frame_start` pulses once per chip-select falling edge, and `frame_end` pulses once per following rising edge.
- R8: If chip select is low when reset is released, no frame starts and `sdo_oe` stays 0 until chip select has gone high and then low again.
- R9: A rising serial-clock edge seen in the same synchronised cycle as the chip-select rising edge still counts. If it completes a byte, `rx_valid` and `frame_end` pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select from the host, active low |
| sck_pin | input | 1 | Serial clock from the host |
| sdi_pin | input | 1 | Serial data from the host |
| tx_byte | input | WORD_W | Next byte to send, supplied by the command logic |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the serial data pad (0 = high impedance) |
| mode_is3 | output | 1 | Detected clock mode: 1 = mode 3, 0 = mode 0 |
| frame_start | output | 1 | One-cycle pulse when a frame begins |
| frame_end | output | 1 | One-cycle pulse when a frame ends |
| rx_data | output | WORD_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` holds a new byte |
| tx_load | output | 1 | One-cycle pulse when `tx_byte` has been taken |

## Verification
Completing a received byte and ending a frame can land in the same system-clock cycle. This happens when the host raises the serial clock for the eighth bit at the same moment it releases chip select. The bench provokes it in a mode-3 frame by changing both pins on the same edge. It requires that the byte is delivered intact and that `rx_valid` and `frame_end` are seen together in one cycle. Random frames of both modes, with byte counts and partial bytes, surround this case. Each transmitted bit is checked just before the rising edge that the host would sample on.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef enum logic {
    SPI_M0 = 1'b0,
    SPI_M3 = 1'b1
  } spi_mode_e;

  // idle clock level at select time picks the mode
  function automatic spi_mode_e mode_from_idle(input logic idle_level);
    return idle_level ? SPI_M3 : SPI_M0;
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
        else        chain <= {chain[STAGES-2:0], d_in[g]};
      end
      assign d_out[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_slv_frame.sv
module spi_slv_frame
  import spi_slv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic sck_s,
  output logic start_ev,
  output logic end_ev,
  output logic rise_ev,
  output logic fall_ev,
  output logic in_frame,
  output logic mode_is3,
  output logic start_p,
  output logic end_p
);

  logic      cs_q;
  logic      sck_q;
  spi_mode_e mode;

  // cs_q resets to 0, so a fall needs a real high level seen first
  assign start_ev = cs_q & ~cs_s;
  assign end_ev   = ~cs_q & cs_s & in_frame;
  assign rise_ev  = in_frame & ~sck_q & sck_s;
  assign fall_ev  = in_frame & sck_q & ~sck_s;
  assign mode_is3 = (mode == SPI_M3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      sck_q    <= 1'b1;
      in_frame <= 1'b0;
      mode     <= SPI_M3;
      start_p  <= 1'b0;
      end_p    <= 1'b0;
    end else begin
      cs_q    <= cs_s;
      sck_q   <= sck_s;
      start_p <= start_ev;
      end_p   <= end_ev;
      if (start_ev) begin
        in_frame <= 1'b1;
        mode     <= mode_from_idle(sck_s);
      end else if (cs_s) begin
        in_frame <= 1'b0;
      end
    end
  end

  a_r2_mode_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (mode_is3 == $past(sck_s)));

  a_r7_end_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    end_p |-> !start_p);

endmodule

// File: rtl/spi_slv_rx.sv
module spi_slv_rx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              rise_ev,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] s, input logic b);
    return {s[WORD_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (start_ev) begin
        cnt <= '0;
      end else if (rise_ev) begin
        sr  <= push_bit(sr, sdi_s);
        cnt <= next_cnt(cnt);
        if (cnt == LAST) begin
          rx_data  <= push_bit(sr, sdi_s);
          rx_valid <= 1'b1;
        end
      end
    end
  end

  a_r3_valid_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(rise_ev));

endmodule

// File: rtl/spi_slv_tx.sv
module spi_slv_tx #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ev,
  input  logic              end_ev,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              tx_load
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              rise_seen;
  logic              shift_ev;

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  // a falling edge before any rising edge (mode 3 lead-in) does not shift
  assign shift_ev = fall_ev & rise_seen;
  assign sdo      = sr[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      rise_seen <= 1'b0;
      sdo_oe    <= 1'b0;
      tx_load   <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (start_ev) begin
        sr        <= tx_byte;
        cnt       <= '0;
        rise_seen <= 1'b0;
        sdo_oe    <= 1'b1;
        tx_load   <= 1'b1;
      end else begin
        if (end_ev)  sdo_oe    <= 1'b0;
        if (rise_ev) rise_seen <= 1'b1;
        if (shift_ev) begin
          cnt <= next_cnt(cnt);
          if (cnt == LAST) begin
            sr      <= tx_byte;
            tx_load <= 1'b1;
          end else begin
            sr <= {sr[WORD_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  a_r5_load_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> ($past(start_ev) || $past(shift_ev)));

endmodule

// File: rtl/spi_autodetect_slave.sv
module spi_autodetect_slave #(
  parameter int WORD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_pin,
  input  logic              sck_pin,
  input  logic              sdi_pin,
  input  logic [WORD_W-1:0] tx_byte,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              mode_is3,
  output logic              frame_start,
  output logic              frame_end,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_load
);

  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b010; // {sdi, sck, cs}

  logic [PIN_N-1:0] pins_s;
  logic cs_s, sck_s, sdi_s;
  logic start_ev, end_ev, rise_ev, fall_ev, in_frame;

  spi_slv_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({sdi_pin, sck_pin, cs_n_pin}),
    .d_out (pins_s)
  );

  assign cs_s  = pins_s[0];
  assign sck_s = pins_s[1];
  assign sdi_s = pins_s[2];

  spi_slv_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sck_s    (sck_s),
    .start_ev (start_ev),
    .end_ev   (end_ev),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .in_frame (in_frame),
    .mode_is3 (mode_is3),
    .start_p  (frame_start),
    .end_p    (frame_end)
  );

  spi_slv_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .rise_ev  (rise_ev),
    .sdi_s    (sdi_s),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  spi_slv_tx #(.WORD_W(WORD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .end_ev   (end_ev),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .tx_byte  (tx_byte),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .tx_load  (tx_load)
  );

  a_r6_oe_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> in_frame);

  a_r4_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_frame) && in_frame && !$past(fall_ev)) |-> $stable(sdo));

  a_r5_load_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> tx_load);

endmodule

// File: tb/test_spi_autodetect_slave.sv
module test_spi_autodetect_slave;

  localparam int HP = 8; // system clocks per serial half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b1;
  logic       sdi = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       sdo, sdo_oe, mode_is3, frame_start, frame_end, rx_valid, tx_load;
  logic [7:0] rx_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] tx_list [0:15];
  logic [7:0] rxb     [0:15];
  logic [7:0] rx_got  [0:63];
  int rx_n = 0, fs_n = 0, fe_n = 0, co_n = 0, tx_idx = 0;

  always #2.5 clk = ~clk;

  spi_autodetect_slave i_spi_autodetect_slave (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .sdi_pin(sdi),
    .tx_byte(tx_byte), .sdo(sdo), .sdo_oe(sdo_oe), .mode_is3(mode_is3),
    .frame_start(frame_start), .frame_end(frame_end), .rx_data(rx_data),
    .rx_valid(rx_valid), .tx_load(tx_load)
  );

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rx_valid) begin
      if (rx_n < 64) rx_got[rx_n] = rx_data;
      rx_n++;
    end
    if (frame_start) fs_n++;
    if (frame_end) fe_n++;
    if (rx_valid && frame_end) co_n++;
    if (tx_load) begin
      tx_idx++;
      if (tx_idx < 16) tx_byte = tx_list[tx_idx];
    end
  end

  function automatic logic exp_bit(input logic [7:0] b, input int pos);
    return b[7 - (pos % 8)];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_frame(input bit m3, input int nbits, input bit coincide);
    int rx0, fs0, fe0, co0;
    rx0 = rx_n; fs0 = fs_n; fe0 = fe_n; co0 = co_n;
    for (int k = 0; k < 16; k++) begin
      tx_list[k] = 8'($urandom);
      rxb[k]     = 8'($urandom);
    end
    tx_idx = 0;
    tx_byte = tx_list[0];
    sck = m3;
    wt(HP);
    cs_n = 1'b0;
    wt(HP);
    chk("R2 mode", {31'd0, mode_is3}, {31'd0, m3});
    chk("R7 start", fs_n - fs0, 1);
    chk("R5 oe", {31'd0, sdo_oe}, 1);
    for (int j = 0; j < nbits; j++) begin
      if (m3) begin
        sck = 1'b0;
        sdi = exp_bit(rxb[j / 8], j);
        wt(HP);
        chk("R4 sdo", {31'd0, sdo}, {31'd0, exp_bit(tx_list[j / 8], j)});
        sck = 1'b1;
        if (coincide && j == nbits - 1) cs_n = 1'b1;
        wt(HP);
      end else begin
        sdi = exp_bit(rxb[j / 8], j);
        wt(HP);
        chk(j == 0 ? "R5 first bit" : "R4 sdo", {31'd0, sdo},
            {31'd0, exp_bit(tx_list[j / 8], j)});
        sck = 1'b1;
        wt(HP);
        sck = 1'b0;
      end
    end
    if (!coincide) begin
      wt(HP);
      cs_n = 1'b1;
    end
    wt(2 * HP);
    chk("R3 count", rx_n - rx0, nbits / 8);
    for (int k = 0; k < nbits / 8; k++)
      chk("R3 byte", {24'd0, rx_got[rx0 + k]}, {24'd0, rxb[k]});
    chk("R7 end", fe_n - fe0, 1);
    chk("R6 oe off", {31'd0, sdo_oe}, 0);
    if (coincide) chk("R9 same cycle", co_n - co0, 1);
  endtask

  initial begin
    int seed, rx0, fs0, bits, m;
    seed = $urandom(32'd4242);
    wt(3);
    chk("R1 mode", {31'd0, mode_is3}, 1);
    chk("R1 oe", {31'd0, sdo_oe}, 0);
    rst_n = 1'b1;
    wt(6);
    chk("R1 mode after", {31'd0, mode_is3}, 1);
    chk("R1 quiet", rx_n + fs_n + fe_n, 0);

    // directed: both modes, then random frames
    do_frame(1'b0, 16, 1'b0);
    do_frame(1'b1, 16, 1'b0);
    do_frame(1'b0, 11, 1'b0); // partial byte discarded (R3)
    for (int f = 0; f < 8; f++) begin
      m = $urandom % 2;
      bits = 8 * (1 + $urandom % 3) + ((($urandom % 3) == 0) ? 3 : 0);
      do_frame(m[0], bits, 1'b0);
    end
    do_frame(1'b1, 8, 1'b1);   // R9 coincident edge
    do_frame(1'b1, 24, 1'b1);

    // R6: activity with chip select high
    rx0 = rx_n; fs0 = fs_n;
    for (int i = 0; i < 20; i++) begin
      sck = ~sck; sdi = $urandom % 2; wt(HP);
    end
    chk("R6 no rx", rx_n - rx0, 0);
    chk("R6 no start", fs_n - fs0, 0);
    chk("R6 oe", {31'd0, sdo_oe}, 0);

    // R8: reset released with chip select low after a mode-0 frame
    do_frame(1'b0, 8, 1'b0);
    sck = 1'b0;
    cs_n = 1'b0;
    wt(HP);
    rst_n = 1'b0;
    wt(4);
    rst_n = 1'b1;
    wt(HP);
    chk("R1 mode back to 3", {31'd0, mode_is3}, 1);
    rx0 = rx_n; fs0 = fs_n;
    for (int i = 0; i < 32; i++) begin
      sck = ~sck; sdi = $urandom % 2; wt(HP);
      if (sdo_oe !== 1'b0) chk("R8 oe held low", {31'd0, sdo_oe}, 0);
    end
    chk("R8 no start", fs_n - fs0, 0);
    chk("R8 no rx", rx_n - rx0, 0);
    cs_n = 1'b1;
    wt(2 * HP);
    do_frame(1'b0, 16, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule